// File: doc/BRIEF.md
# Per-Nibble Delay-Sweep Transition Detector

This block belongs to a read-preamble training engine for buffered memory modules. A controller steps a phase delay through every setting of its range. At each setting it presents one sampled byte per data buffer. The block splits each byte into two nibble results and keeps a small recorder for every nibble. A recorder notes whether an all-low sample has been seen and whether an all-high sample has been seen after it. It also captures the delay at which that low-to-high edge first appears.

The sweep may be repeated a fixed number of times to reduce noise, and the recorders keep their state across the repeats. When the final pass ends, the block adds a fixed offset to every captured delay. That offset depends on the preamble length, and the sum wraps within the delay range. The block then publishes the per-nibble delays, a bitmap of nibbles that never showed an edge, a bitmap of nibbles that returned mixed patterns, and a saturating total of mixed samples. It marks the moment the results become valid with a one-cycle pulse.

The controller FSM has four states. IDLE waits. SWEEP collects samples. ADJUST is a single cycle in which the offset results are loaded. REPORT is a single cycle that drives the done pulse. The transitions are named as follows. "begin" goes from any state to SWEEP when start is asserted. "final-point" goes from SWEEP to ADJUST on a valid sample at the top delay of the last pass. "publish" goes from ADJUST to REPORT. "retire" goes from REPORT to IDLE.

Top module: `nibble_edge_finder`

## Requirements
- R1: After reset, done is low and all delay outputs, both bitmaps and the total are zero.
- R2: For buffer b, nibble 2b is bits [8b+7:8b+4] of the sample vector and nibble 2b+1 is bits [8b+3:8b]. A nibble value of 4'h0 counts as low and a value of 4'hF counts as high.
- R3: A high sample sets a nibble's seen-high flag only if a low sample was seen earlier. A high seen before any low does not count.
- R4: A nibble's stored delay is written with the current delay index once both flags are set and the stored value is zero. After that it keeps its value for the rest of the run.
- R5: A nibble value other than 4'h0 or 4'hF increments that nibble's invalid counter, which saturates at its maximum. Such a value changes neither flag.
- R6: The reported delay equals the stored delay plus 32 when the preamble input is low (one cycle), or plus 64 when it is high (two cycles), taken modulo 64. The preamble input is captured when start is asserted.
- R7: Bit n of the no-edge bitmap is 1 when nibble n lacks its seen-low or its seen-high flag.
- R8: Bit n of the invalid bitmap is 1 when nibble n's invalid counter is nonzero. The total output is the sum of all nibble counters, saturated at its all-ones value.
- R9: The run ends on a valid sample at delay index 63 during the last of PASSES passes. All flags carry over between passes. Done is high for exactly one cycle, two clock edges after that final sample.
- R10: Start clears all recorders and begins a new run from any state, including partway through a sweep. Results hold their values from done until the next run completes.
- R11: Samples with the valid strobe low, and samples presented while no run is active, have no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that clears the recorders and starts a run |
| long_pre_i | input | 1 | Preamble length: 0 for one cycle, 1 for two cycles; captured with start |
| smp_valid_i | input | 1 | Sample strobe |
| smp_dly_i | input | DLY_W | Delay index of the current sample |
| smp_data_i | input | 8*NUM_BUF | One sampled byte per buffer |
| done_o | output | 1 | One-cycle pulse when the results are valid |
| dly_o | output | 2*NUM_BUF*DLY_W | Offset delay of each nibble; nibble n is at [n*DLY_W +: DLY_W] |
| notrans_o | output | 2*NUM_BUF | No-edge bitmap, one bit per nibble |
| invalid_o | output | 2*NUM_BUF | Invalid-data bitmap, one bit per nibble |
| inv_total_o | output | TOT_W | Saturating sum of the invalid counts |

## Verification
The bench builds the block with four buffers (eight nibbles), a 6-bit delay, two passes, 4-bit nibble counters and a 6-bit total. With these values, a nibble that returns a mixed pattern on every sample saturates its counter within one run, and eight such nibbles push the total past its limit. A full 64-step delay range is kept, so the offset wrap and the carry of flags across passes can both be exercised. This includes an edge that appears only at the seam between the end of the first pass and the start of the second.

// File: rtl/dsweep_pkg.sv
package dsweep_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SWEEP  = 2'd1,
        ST_ADJUST = 2'd2,
        ST_REPORT = 2'd3
    } sweep_state_e;

    localparam logic [3:0] NIB_LOW  = 4'h0;
    localparam logic [3:0] NIB_HIGH = 4'hF;

endpackage

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
    import dsweep_pkg::*;
#(
    parameter int DLY_W  = 6,
    parameter int PASSES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             smp_valid_i,
    input  logic [DLY_W-1:0] smp_dly_i,
    output sweep_state_e     state_o,
    output logic             upd_o
);

    localparam int PASS_W = $clog2(PASSES) + 1;
    localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(PASSES - 1);

    sweep_state_e      state_q, state_d;
    logic [PASS_W-1:0] pass_q;
    logic              top_point;

    assign top_point = smp_valid_i && (smp_dly_i == '1);

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = ST_IDLE;
            ST_SWEEP:  if (top_point && (pass_q == LAST_PASS)) state_d = ST_ADJUST;
            ST_ADJUST: state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (start_i) state_d = ST_SWEEP;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // pass counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   pass_q <= '0;
        else if (start_i)                             pass_q <= '0;
        else if ((state_q == ST_SWEEP) && top_point)  pass_q <= pass_q + 1'b1;
    end

    // outputs
    always_comb begin
        state_o = state_q;
        upd_o   = (state_q == ST_SWEEP) && smp_valid_i && !start_i;
    end

endmodule

// File: rtl/nib_recorder.sv
module nib_recorder
    import dsweep_pkg::*;
#(
    parameter int DLY_W = 6,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             upd_i,
    input  logic [3:0]       nib_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             seen_lo_o,
    output logic             seen_hi_o,
    output logic [DLY_W-1:0] dly_o,
    output logic [CNT_W-1:0] cnt_o
);

    logic             lo_q, hi_q, lo_n, hi_n;
    logic [DLY_W-1:0] dly_q;
    logic [CNT_W-1:0] cnt_q;
    logic             is_lo, is_hi, is_bad;

    always_comb begin
        is_lo  = (nib_i == NIB_LOW);
        is_hi  = (nib_i == NIB_HIGH);
        is_bad = !is_lo && !is_hi;
        lo_n   = lo_q | is_lo;
        hi_n   = hi_q | (is_hi & lo_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q  <= 1'b0;
            hi_q  <= 1'b0;
            dly_q <= '0;
            cnt_q <= '0;
        end else if (clr_i) begin
            lo_q  <= 1'b0;
            hi_q  <= 1'b0;
            dly_q <= '0;
            cnt_q <= '0;
        end else if (upd_i) begin
            lo_q <= lo_n;
            hi_q <= hi_n;
            if (is_bad && (cnt_q != '1)) cnt_q <= cnt_q + 1'b1;
            if (lo_n && hi_n && (dly_q == '0)) dly_q <= dly_i;
        end
    end

    assign seen_lo_o = lo_q;
    assign seen_hi_o = hi_q;
    assign dly_o     = dly_q;
    assign cnt_o     = cnt_q;

endmodule

// File: rtl/nibble_edge_finder.sv
module nibble_edge_finder
    import dsweep_pkg::*;
#(
    parameter int NUM_BUF   = 9,
    parameter int DLY_W     = 6,
    parameter int PASSES    = 2,
    parameter int CNT_W     = 16,
    parameter int TOT_W     = 16,
    parameter int OFF_SHORT = 32,
    parameter int OFF_LONG  = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     long_pre_i,
    input  logic                     smp_valid_i,
    input  logic [DLY_W-1:0]         smp_dly_i,
    input  logic [8*NUM_BUF-1:0]     smp_data_i,
    output logic                     done_o,
    output logic [2*NUM_BUF*DLY_W-1:0] dly_o,
    output logic [2*NUM_BUF-1:0]     notrans_o,
    output logic [2*NUM_BUF-1:0]     invalid_o,
    output logic [TOT_W-1:0]         inv_total_o
);

    localparam int NIB       = 2 * NUM_BUF;
    localparam int DLY_RANGE = 1 << DLY_W;
    localparam int SUM_W     = CNT_W + $clog2(NIB) + 1;
    localparam logic [DLY_W-1:0] OFF_S = DLY_W'(OFF_SHORT % DLY_RANGE);
    localparam logic [DLY_W-1:0] OFF_L = DLY_W'(OFF_LONG % DLY_RANGE);

    sweep_state_e     state;
    logic             upd, load, pre_q;
    logic [DLY_W-1:0] off;
    logic             lo_a  [NIB];
    logic             hi_a  [NIB];
    logic [DLY_W-1:0] dly_a [NIB];
    logic [CNT_W-1:0] cnt_a [NIB];
    logic [SUM_W-1:0] sum_c;
    logic [SUM_W-1:0] tot_lim;
    logic [TOT_W-1:0] tot_c, tot_q;

    sweep_ctrl #(.DLY_W(DLY_W), .PASSES(PASSES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .smp_valid_i(smp_valid_i),
        .smp_dly_i  (smp_dly_i),
        .state_o    (state),
        .upd_o      (upd)
    );

    assign load   = (state == ST_ADJUST) && !start_i;
    assign done_o = (state == ST_REPORT);
    assign off    = pre_q ? OFF_L : OFF_S;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pre_q <= 1'b0;
        else if (start_i) pre_q <= long_pre_i;
    end

    for (genvar n = 0; n < NIB; n++) begin : g_nib
        localparam int LSB = 8 * (n / 2) + (((n % 2) == 0) ? 4 : 0);
        logic [DLY_W-1:0] res_dly_q;
        logic             res_nt_q, res_iv_q;

        nib_recorder #(.DLY_W(DLY_W), .CNT_W(CNT_W)) u_rec (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (start_i),
            .upd_i    (upd),
            .nib_i    (smp_data_i[LSB +: 4]),
            .dly_i    (smp_dly_i),
            .seen_lo_o(lo_a[n]),
            .seen_hi_o(hi_a[n]),
            .dly_o    (dly_a[n]),
            .cnt_o    (cnt_a[n])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_dly_q <= '0;
                res_nt_q  <= 1'b0;
                res_iv_q  <= 1'b0;
            end else if (load) begin
                res_dly_q <= dly_a[n] + off;
                res_nt_q  <= !(lo_a[n] && hi_a[n]);
                res_iv_q  <= (cnt_a[n] != '0);
            end
        end

        assign dly_o[n*DLY_W +: DLY_W] = res_dly_q;
        assign notrans_o[n]            = res_nt_q;
        assign invalid_o[n]            = res_iv_q;
    end

    // saturating total of the nibble counters
    always_comb begin
        tot_lim = SUM_W'({TOT_W{1'b1}});
        sum_c   = '0;
        for (int n = 0; n < NIB; n++) sum_c = sum_c + SUM_W'(cnt_a[n]);
        tot_c = (sum_c > tot_lim) ? '1 : TOT_W'(sum_c);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    tot_q <= '0;
        else if (load) tot_q <= tot_c;
    end

    assign inv_total_o = tot_q;

endmodule

// File: rtl/nibble_edge_finder_chk.sv
module nibble_edge_finder_chk
    import dsweep_pkg::*;
#(
    parameter int NIB   = 18,
    parameter int DLY_W = 6,
    parameter int TOT_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_i,
    input logic                 done_o,
    input sweep_state_e         state_i,
    input logic [NIB*DLY_W-1:0] dly_o,
    input logic [NIB-1:0]       notrans_o,
    input logic [NIB-1:0]       invalid_o,
    input logic [TOT_W-1:0]     inv_total_o
);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_after_adjust_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(state_i) == ST_ADJUST));

    // R10
    start_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_i == ST_SWEEP));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (done_o || ($stable(dly_o) && $stable(notrans_o)
                  && $stable(invalid_o) && $stable(inv_total_o))));

    // R8
    total_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((inv_total_o == '0) == (invalid_o == '0)));

endmodule

bind nibble_edge_finder nibble_edge_finder_chk #(
    .NIB  (NIB),
    .DLY_W(DLY_W),
    .TOT_W(TOT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .done_o     (done_o),
    .state_i    (state),
    .dly_o      (dly_o),
    .notrans_o  (notrans_o),
    .invalid_o  (invalid_o),
    .inv_total_o(inv_total_o)
);

// File: tb/test_nibble_edge_finder.sv
module test_nibble_edge_finder;

    localparam int NB   = 4;
    localparam int NN   = 2 * NB;
    localparam int DW   = 6;
    localparam int NP   = 2;
    localparam int CW   = 4;
    localparam int TW   = 6;
    localparam int CMAX = 15;
    localparam int TMAX = 63;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              long_pre_i = 1'b0;
    logic              smp_valid_i = 1'b0;
    logic [DW-1:0]     smp_dly_i = '0;
    logic [8*NB-1:0]   smp_data_i = '0;
    logic              done_o;
    logic [NN*DW-1:0]  dly_o;
    logic [NN-1:0]     notrans_o, invalid_o;
    logic [TW-1:0]     inv_total_o;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    nibble_edge_finder #(
        .NUM_BUF(NB), .DLY_W(DW), .PASSES(NP), .CNT_W(CW), .TOT_W(TW)
    ) i_nibble_edge_finder (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .long_pre_i(long_pre_i),
        .smp_valid_i(smp_valid_i), .smp_dly_i(smp_dly_i), .smp_data_i(smp_data_i),
        .done_o(done_o), .dly_o(dly_o), .notrans_o(notrans_o),
        .invalid_o(invalid_o), .inv_total_o(inv_total_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural model ----------------
    int  m_lo [NN];
    int  m_hi [NN];
    int  m_st [NN];
    int  m_ct [NN];
    int  m_phase = 0;
    int  m_pass = 0;
    bit  m_pre = 0;
    int  e_dly [NN];
    logic [NN-1:0] e_nt = '0, e_iv = '0;
    int  e_tot = 0;
    bit  e_done = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; e_done = 0; e_nt = '0; e_iv = '0; e_tot = 0;
            for (int n = 0; n < NN; n++) begin
                e_dly[n] = 0; m_lo[n] = 0; m_hi[n] = 0; m_st[n] = 0; m_ct[n] = 0;
            end
        end else begin
            e_done = 0;
            if (start_i) begin
                m_phase = 1; m_pass = 0; m_pre = long_pre_i;
                for (int n = 0; n < NN; n++) begin
                    m_lo[n] = 0; m_hi[n] = 0; m_st[n] = 0; m_ct[n] = 0;
                end
            end else if (m_phase == 1) begin
                if (smp_valid_i) begin
                    for (int n = 0; n < NN; n++) begin
                        int v;
                        v = (smp_data_i >> (8 * (n / 2) + ((n % 2 == 0) ? 4 : 0))) & 15;
                        if (v == 0) m_lo[n] = 1;
                        else if (v == 15) begin
                            if (m_lo[n] == 1) m_hi[n] = 1;
                        end else if (m_ct[n] < CMAX) m_ct[n]++;
                        if (m_lo[n] == 1 && m_hi[n] == 1 && m_st[n] == 0) m_st[n] = int'(smp_dly_i);
                    end
                    if (smp_dly_i == 63) begin
                        m_pass++;
                        if (m_pass == NP) m_phase = 2;
                    end
                end
            end else if (m_phase == 2) begin
                int sum;
                sum = 0;
                for (int n = 0; n < NN; n++) begin
                    e_dly[n] = (m_st[n] + (m_pre ? 64 : 32)) % 64;
                    e_nt[n]  = !(m_lo[n] == 1 && m_hi[n] == 1);
                    e_iv[n]  = (m_ct[n] != 0);
                    sum += m_ct[n];
                end
                e_tot = (sum > TMAX) ? TMAX : sum;
                e_done = 1; m_phase = 3;
            end else if (m_phase == 3) begin
                m_phase = 0;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [NN*DW-1:0] ed;
            for (int n = 0; n < NN; n++) ed[n*DW +: DW] = DW'(e_dly[n]);
            check("R9 done pulse", 64'(done_o), 64'(e_done));
            check("R6 delays", 64'(dly_o), 64'(ed));
            check("R7 no-edge map", 64'(notrans_o), 64'(e_nt));
            check("R8 invalid map", 64'(invalid_o), 64'(e_iv));
            check("R8 total", 64'(inv_total_o), 64'(e_tot));
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [3:0] nv(input int scn, input int n, input int d);
        case (scn)
            0: return (d < 5 + 3 * n) ? 4'h0 : 4'hF;
            1: begin
                if (n < 5)  return (d < 40 + 2 * n) ? 4'h0 : 4'hF;
                if (n == 5) return (d < 10 || d >= 20) ? 4'hF : 4'h0;
                if (n == 6) return 4'h0;
                return 4'hF;
            end
            2: begin
                if (n == 0) return (d == 63) ? 4'h0 : 4'hF;
                if (n == 1) return 4'h5;
                if (n == 3) return (d == 7) ? 4'hA : ((d < 30) ? 4'h0 : 4'hF);
                return (d < 50) ? 4'h0 : 4'hF;
            end
            default: return 4'h3;
        endcase
    endfunction

    function automatic logic [8*NB-1:0] pack(input int scn, input int d);
        logic [8*NB-1:0] v;
        v = '0;
        // R2: even nibble in the upper half of its byte, odd nibble in the lower
        for (int n = 0; n < NN; n++) v[8 * (n / 2) + ((n % 2 == 0) ? 4 : 0) +: 4] = nv(scn, n, d);
        return v;
    endfunction

    task automatic run_scn(input int scn, input bit pre, input int limit, input bit gaps);
        int cnt;
        cnt = 0;
        start_i = 1'b1; long_pre_i = pre;
        @(negedge clk);
        start_i = 1'b0; long_pre_i = ~pre;
        for (int p = 0; p < NP; p++) begin
            for (int d = 0; d < 64; d++) begin
                if (limit >= 0 && cnt == limit) return;
                if (gaps) begin
                    // R11: strobe low with garbage data
                    smp_valid_i = 1'b0; smp_data_i = {NB{8'h5A}}; smp_dly_i = DW'(d);
                    @(negedge clk);
                end
                smp_valid_i = 1'b1; smp_dly_i = DW'(d); smp_data_i = pack(scn, d);
                @(negedge clk);
                cnt++;
            end
        end
        smp_valid_i = 1'b0;
        @(negedge clk);
        check("R9 done high two edges after final sample", 64'(done_o), 64'd1);
        @(negedge clk);
        check("R9 done falls after one cycle", 64'(done_o), 64'd0);
    endtask

    function automatic logic [63:0] nd(input int n);
        return 64'(dly_o[n*DW +: DW]);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset done", 64'(done_o), 64'd0);
        check("R1 reset delays", 64'(dly_o), 64'd0);
        check("R1 reset maps", 64'({notrans_o, invalid_o}), 64'd0);
        check("R1 reset total", 64'(inv_total_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // short preamble, staggered edges
        run_scn(0, 1'b0, -1, 1'b0);
        check("R6 nibble0 5+32", nd(0), 64'd37);
        check("R2 nibble1 is lower half of byte0", nd(1), 64'd40);
        check("R6 nibble7", nd(7), 64'd58);
        check("R7 all edges found", 64'(notrans_o), 64'd0);

        // long preamble, late high, stuck nibbles
        run_scn(1, 1'b1, -1, 1'b0);
        check("R6 long preamble unchanged", nd(0), 64'd40);
        check("R3 high before low ignored", nd(5), 64'd20);
        check("R7 stuck nibbles flagged", 64'(notrans_o), 64'hC0);

        // invalid data, seam edge, wrap
        run_scn(2, 1'b0, -1, 1'b0);
        check("R4 seam edge re-latched past zero", nd(0), 64'd33);
        check("R6 wrap 50+32", nd(2), 64'd18);
        check("R5 invalid leaves flags, edge found", nd(3), 64'd62);
        check("R5 all-invalid nibble has no edge", 64'(notrans_o[1]), 64'd1);
        check("R8 invalid map", 64'(invalid_o), 64'h0A);
        check("R8 total 15+2", 64'(inv_total_o), 64'd17);

        // total saturation
        run_scn(3, 1'b0, -1, 1'b0);
        check("R8 total saturates", 64'(inv_total_o), 64'd63);
        check("R5 every nibble invalid", 64'(invalid_o), 64'hFF);

        // R11: samples with no run active
        for (int k = 0; k < 5; k++) begin
            smp_valid_i = 1'b1; smp_dly_i = 6'd63; smp_data_i = '0;
            @(negedge clk);
        end
        smp_valid_i = 1'b0;
        @(negedge clk);
        check("R11 idle samples ignored", 64'(inv_total_o), 64'd63);
        check("R10 results held", 64'(done_o), 64'd0);

        // R10: restart partway through, with strobe-low gaps
        run_scn(1, 1'b1, 20, 1'b0);
        run_scn(0, 1'b0, -1, 1'b1);
        check("R10 restart result", nd(0), 64'd37);
        check("R11 gaps ignored", 64'(inv_total_o), 64'd0);

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule